// File: doc/BRIEF.md
# Four-Phase Command/Flag Handshake Pacer

This block sets the pace at which test patterns are handed to an external device. In handshake mode each new pattern causes the block to raise a command line. It then waits for the device to raise its flag in acknowledgment and drops the command. The flag must then fall and rise again, so every step is a complete four-phase exchange. Only after that return does the block pulse an advance enable to the pattern sequencer. In the same cycle it opens the gate of the synchronised test clock output.

When handshake mode is off, the block does not hold anything back. The advance enable follows pattern-ready directly and the clock gate stays open, so the clocks run freely. The external flag is asynchronous to the test clock. It passes through a parameterised flop synchroniser before the state machine uses it.

Top module: `hs_pacer`

## Requirements
- R1: After synchronous reset with handshake mode on, `cmd_o`, `adv_o`, `busy_o` and `clk_gate_o` are all 0.
- R2: In handshake mode, when idle and `pat_rdy` is 1 at a clock edge, `cmd_o` and `busy_o` are 1 after that edge.
- R3: `cmd_o` stays 1 until the synchronised flag is seen high. It falls at the third rising edge after `ext_flag` rises: two synchroniser stages plus one state update.
- R4: After the command drops, a flag that stays high gives no advance. `busy_o` stays 1 until the flag has gone low and then high again.
- R5: The flag's low-to-high return causes `adv_o` and `clk_gate_o` to be 1 for exactly one cycle, starting at the third rising edge after the rise, with `busy_o` 0 in that cycle.
- R6: While idle in handshake mode with `pat_rdy` at 0, activity on `ext_flag` raises none of `cmd_o`, `adv_o` or `busy_o`.
- R7: With handshake mode off (`hs_en` = 0), `adv_o` equals `pat_rdy` in the same cycle, `clk_gate_o` is 1, and `cmd_o` and `busy_o` are 0 once the mode has been off for one edge.
- R8: Clearing `hs_en` in the middle of an exchange returns the block to idle at the next edge: `cmd_o` 0, `busy_o` 0.
- R9: While an exchange is past its command phase, `pat_rdy` held at 1 does not raise `cmd_o` again before the advance pulse. The next command follows at the edge after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_en | input | 1 | 1 selects handshake mode, 0 selects free-running |
| pat_rdy | input | 1 | A new test pattern is ready to present |
| ext_flag | input | 1 | Asynchronous acknowledge from the external device, positive true |
| cmd_o | output | 1 | Command to the external device, positive true |
| adv_o | output | 1 | Advance enable to the pattern sequencer |
| busy_o | output | 1 | An exchange is in progress |
| clk_gate_o | output | 1 | Enable for the synchronised clock output |

## Verification
The full exchange is driven with the flag rising, falling and rising again. The bench samples one cycle before and one cycle after each expected transition, which pins down the synchroniser latency. A flag held high after the acknowledgment tells a true four-phase controller apart from one that advances on level. Flag activity while idle exposes a controller that reacts to an acknowledgment it never requested. Pattern-ready held high through the wait states, and an abort mid-exchange, separate correct sequencing from early re-issue or stuck states. Free-running mode with a toggling ready line shows that the pacing is bypassed.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
package hs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CMD    = 2'd1,
        ST_WLOW   = 2'd2,
        ST_WHIGH  = 2'd3
    } hs_state_e;

    localparam int unsigned DEF_SYNC_STAGES = 2;

    function automatic logic in_exchange(input hs_state_e s);
        return s != ST_IDLE;
    endfunction

    function automatic logic past_command(input hs_state_e s);
        return (s == ST_WLOW) || (s == ST_WHIGH);
    endfunction
endpackage

// File: rtl/hs_sync.sv
`timescale 1ns/1ps
module hs_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hs_fsm.sv
`timescale 1ns/1ps
module hs_fsm
    import hs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hs_en,
    input  logic      pat_rdy,
    input  logic      flag_s,
    output hs_state_e state_o,
    output logic      step_o
);
    hs_state_e state_q, state_d;
    logic      step_d;

    always_comb begin
        state_d = state_q;
        step_d  = 1'b0;
        if (!hs_en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (pat_rdy) state_d = ST_CMD;
                ST_CMD:   if (flag_s)  state_d = ST_WLOW;
                ST_WLOW:  if (!flag_s) state_d = ST_WHIGH;
                ST_WHIGH: if (flag_s) begin
                    state_d = ST_IDLE;
                    step_d  = 1'b1;
                end
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_o  <= 1'b0;
        end else begin
            state_q <= state_d;
            step_o  <= step_d;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/hs_out.sv
`timescale 1ns/1ps
module hs_out
    import hs_pkg::*;
(
    input  logic      hs_en,
    input  logic      pat_rdy,
    input  hs_state_e state_i,
    input  logic      step_i,
    output logic      cmd_o,
    output logic      adv_o,
    output logic      busy_o,
    output logic      clk_gate_o
);
    always_comb begin
        cmd_o  = (state_i == ST_CMD);
        busy_o = in_exchange(state_i);
        if (hs_en) begin
            adv_o      = step_i;
            clk_gate_o = step_i;
        end else begin
            adv_o      = pat_rdy;
            clk_gate_o = 1'b1;
        end
    end
endmodule

// File: rtl/hs_pacer.sv
`timescale 1ns/1ps
module hs_pacer
    import hs_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic hs_en,
    input  logic pat_rdy,
    input  logic ext_flag,
    output logic cmd_o,
    output logic adv_o,
    output logic busy_o,
    output logic clk_gate_o
);
    logic      flag_s;
    hs_state_e state;
    logic      step;

    hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ext_flag),
        .q_o (flag_s)
    );

    hs_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .hs_en   (hs_en),
        .pat_rdy (pat_rdy),
        .flag_s  (flag_s),
        .state_o (state),
        .step_o  (step)
    );

    hs_out u_out (
        .hs_en      (hs_en),
        .pat_rdy    (pat_rdy),
        .state_i    (state),
        .step_i     (step),
        .cmd_o      (cmd_o),
        .adv_o      (adv_o),
        .busy_o     (busy_o),
        .clk_gate_o (clk_gate_o)
    );
endmodule

// File: rtl/hs_pacer_chk.sv
`timescale 1ns/1ps
module hs_pacer_chk (
    input logic clk,
    input logic rst,
    input logic hs_en,
    input logic flag_s,
    input logic cmd_o,
    input logic adv_o,
    input logic busy_o,
    input logic clk_gate_o
);
    assert_cmd_busy_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_o |-> busy_o);

    assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_o && !flag_s && hs_en) |=> cmd_o);

    assert_adv_single_R5: assert property (@(posedge clk) disable iff (rst)
        (adv_o && hs_en) |=> (!adv_o || !hs_en));

    assert_adv_after_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (adv_o && hs_en && $past(hs_en)) |-> ($past(busy_o) && !busy_o && clk_gate_o));

    assert_free_run_R7: assert property (@(posedge clk) disable iff (rst)
        (!hs_en && $past(!hs_en)) |-> (!busy_o && !cmd_o && clk_gate_o));

    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !hs_en |=> !busy_o);

    assert_no_reissue_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !cmd_o) |=> !cmd_o);
endmodule

bind hs_pacer hs_pacer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .hs_en      (hs_en),
    .flag_s     (flag_s),
    .cmd_o      (cmd_o),
    .adv_o      (adv_o),
    .busy_o     (busy_o),
    .clk_gate_o (clk_gate_o)
);

// File: tb/hs_pacer_tb_top.sv
`timescale 1ns/1ps
module hs_pacer_tb_top;
    logic clk = 1'b0;
    logic rst, hs_en, pat_rdy, ext_flag;
    logic cmd_o, adv_o, busy_o, clk_gate_o;
    int   n_chk = 0;
    int   n_bad = 0;

    always #2.5 clk = ~clk;

    hs_pacer dut_i (
        .clk(clk), .rst(rst), .hs_en(hs_en), .pat_rdy(pat_rdy), .ext_flag(ext_flag),
        .cmd_o(cmd_o), .adv_o(adv_o), .busy_o(busy_o), .clk_gate_o(clk_gate_o)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // advance n rising edges and settle at the following falling edge
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1; hs_en = 1'b1; pat_rdy = 1'b0; ext_flag = 1'b0;
        edges(3);
        rst = 1'b0;
        edges(1);
        chk("R1", "cmd", cmd_o, 1'b0);
        chk("R1", "adv", adv_o, 1'b0);
        chk("R1", "busy", busy_o, 1'b0);
        chk("R1", "gate", clk_gate_o, 1'b0);
    endtask

    task automatic t_full_exchange;
        pat_rdy = 1'b1;
        edges(1);
        chk("R2", "cmd", cmd_o, 1'b1);
        chk("R2", "busy", busy_o, 1'b1);
        pat_rdy = 1'b0;
        ext_flag = 1'b1;
        edges(2);
        chk("R3", "cmd before sync", cmd_o, 1'b1);
        edges(1);
        chk("R3", "cmd after ack", cmd_o, 1'b0);
        chk("R3", "busy after ack", busy_o, 1'b1);
        ext_flag = 1'b0;
        edges(3);
        chk("R4", "busy after fall", busy_o, 1'b1);
        chk("R4", "adv after fall", adv_o, 1'b0);
        ext_flag = 1'b1;
        edges(2);
        chk("R5", "adv early", adv_o, 1'b0);
        edges(1);
        chk("R5", "adv pulse", adv_o, 1'b1);
        chk("R5", "gate pulse", clk_gate_o, 1'b1);
        chk("R5", "busy at pulse", busy_o, 1'b0);
        edges(1);
        chk("R5", "adv end", adv_o, 1'b0);
        chk("R5", "gate end", clk_gate_o, 1'b0);
        ext_flag = 1'b0;
        edges(3);
    endtask

    task automatic t_flag_stuck_high;
        int seen_adv = 0;
        pat_rdy = 1'b1;
        edges(1);
        pat_rdy = 1'b0;
        ext_flag = 1'b1;
        edges(3);
        for (int i = 0; i < 10; i++) begin
            if (adv_o) seen_adv++;
            edges(1);
        end
        chk("R4", "adv with flag held", (seen_adv != 0), 1'b0);
        chk("R4", "busy with flag held", busy_o, 1'b1);
        ext_flag = 1'b0;
        edges(3);
        ext_flag = 1'b1;
        edges(3);
        chk("R4", "adv after full return", adv_o, 1'b1);
        ext_flag = 1'b0;
        edges(3);
    endtask

    task automatic t_idle_noise;
        int bad = 0;
        pat_rdy = 1'b0;
        for (int i = 0; i < 12; i++) begin
            ext_flag = i[1];
            edges(1);
            if (cmd_o || adv_o || busy_o) bad++;
        end
        chk("R6", "idle outputs under flag noise", (bad != 0), 1'b0);
        ext_flag = 1'b0;
        edges(3);
    endtask

    task automatic t_ready_held;
        int early = 0;
        pat_rdy = 1'b1;
        edges(1);
        ext_flag = 1'b1;
        edges(3);
        ext_flag = 1'b0;
        for (int i = 0; i < 3; i++) begin
            edges(1);
            if (cmd_o) early++;
        end
        ext_flag = 1'b1;
        for (int i = 0; i < 2; i++) begin
            edges(1);
            if (cmd_o) early++;
        end
        chk("R9", "no command in wait states", (early != 0), 1'b0);
        edges(1);
        chk("R9", "adv pulse", adv_o, 1'b1);
        edges(1);
        chk("R9", "next command", cmd_o, 1'b1);
        // abort mid-exchange
        hs_en = 1'b0;
        edges(1);
        chk("R8", "cmd after abort", cmd_o, 1'b0);
        chk("R8", "busy after abort", busy_o, 1'b0);
        ext_flag = 1'b0;
        pat_rdy = 1'b0;
        edges(3);
    endtask

    task automatic t_free_run;
        hs_en = 1'b0;
        edges(2);
        for (int i = 0; i < 4; i++) begin
            pat_rdy = i[0];
            ext_flag = i[1];
            #1;
            chk("R7", "adv follows ready", adv_o, i[0]);
            chk("R7", "gate open", clk_gate_o, 1'b1);
            edges(1);
            chk("R7", "cmd off", cmd_o, 1'b0);
            chk("R7", "busy off", busy_o, 1'b0);
        end
        pat_rdy = 1'b0;
        ext_flag = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_full_exchange();
        t_flag_stuck_high();
        t_idle_noise();
        t_ready_held();
        t_free_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule